// File: doc/BRIEF.md
# Multi-Link SYNC Merger and Fan-Out

When several converter devices share one logic device and bring their links up together, the active-low SYNC signals of the individual links have to be combined. This block does that in both directions. On the transmit side each converter returns its own SYNC line. Every line passes through a two-flop synchronizer, and the enabled lines are then merged into one registered request for the transmit link state machine. The merged request is asserted (low) as soon as any enabled link asserts its line.

On the receive side the receive link state machine produces one SYNC request. The block copies it to every enabled converter through an output register. Disabled converters see a steady deasserted (high) level.

A runtime disable mask, written by software into a configuration register elsewhere, decides which links take part. Bit i of the mask belongs to link i, and a 1 removes that link. The link state machines and the register file are outside this block.

Top module: `msync_fabric`

## Requirements
- R1: During and right after a synchronous active-low reset, `tx_sync_merged_n` and every bit of `rx_sync_out_n` read 1 (deasserted).
- R2: `tx_sync_merged_n` is 0 exactly when at least one link i with `link_off_mask[i]`=0 has `tx_sync_in_n[i]`=0. Otherwise it is 1.
- R3: A link whose `link_off_mask` bit is 1 has no effect on `tx_sync_merged_n`, whatever level its `tx_sync_in_n` bit has.
- R4: When every bit of `link_off_mask` is 1, `tx_sync_merged_n` stays 1.
- R5: A change on `tx_sync_in_n` shows on `tx_sync_merged_n` after exactly three rising clock edges: two synchronizer stages and one output register.
- R6: For every link with `link_off_mask[i]`=0, `rx_sync_out_n[i]` equals `rx_sync_req_n` one rising edge later.
- R7: For every link with `link_off_mask[i]`=1, `rx_sync_out_n[i]` is 1 one rising edge later.
- R8: Mask bit i controls link i only. A mask change takes effect on both outputs after one rising edge.
- R9: `NUM_LINKS` must be between 1 and 8 and `SYNC_STAGES` at least 2. Other values stop elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous reset, active low |
| link_off_mask | input | NUM_LINKS | Per-link disable bits; 1 removes the link |
| tx_sync_in_n | input | NUM_LINKS | Asynchronous SYNC lines returned by the converters, active low |
| tx_sync_merged_n | output | 1 | Merged SYNC request to the transmit state machine, active low |
| rx_sync_req_n | input | 1 | SYNC request from the receive state machine, active low |
| rx_sync_out_n | output | NUM_LINKS | SYNC lines driven to the converters, active low |

## Verification
The bench builds the block with four links, two synchronizer stages and a registered receive fan-out. At that size it can sweep all 16 masks against all 16 transmit input patterns and both receive request levels. This covers every combination of enabled and disabled links, including the all-disabled mask and single-link masks, together with every asserting subset. One dedicated step changes the inputs and samples the merged output after two and after three edges, which pins the transmit latency to an exact cycle.

// File: rtl/msync_pkg.sv
package msync_pkg;
   localparam int unsigned MSYNC_MAX_LINKS = 8;
   localparam int unsigned MSYNC_MIN_STAGES = 2;
   localparam logic        MSYNC_IDLE = 1'b1;   // deasserted level of an active-low SYNC
endpackage

// File: rtl/msync_sync.sv
module msync_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   import msync_pkg::*;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= {STAGES{MSYNC_IDLE}};
         else        chain <= {chain[STAGES-2:0], async_in[b]};
      end
      assign sync_out[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/msync_merge.sv
module msync_merge #(
   parameter int unsigned LINKS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINKS-1:0] off_mask,
   input  logic [LINKS-1:0] sync_n,
   output logic             merged_n
);
   import msync_pkg::*;

   logic [LINKS-1:0] active;   // 1 where an enabled link requests SYNC
   logic             any_req;

   always_comb begin
      active  = ~sync_n & ~off_mask;
      any_req = |active;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) merged_n <= MSYNC_IDLE;
      else        merged_n <= ~any_req;
   end
endmodule

// File: rtl/msync_fanout.sv
module msync_fanout #(
   parameter int unsigned LINKS   = 4,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINKS-1:0] off_mask,
   input  logic             req_n,
   output logic [LINKS-1:0] out_n
);
   import msync_pkg::*;

   logic [LINKS-1:0] next_n;

   for (genvar l = 0; l < LINKS; l++) begin : g_link
      assign next_n[l] = off_mask[l] ? MSYNC_IDLE : req_n;
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) out_n <= {LINKS{MSYNC_IDLE}};
         else        out_n <= next_n;
      end
   end else begin : g_comb
      assign out_n = next_n;
   end
endmodule

// File: rtl/msync_fabric.sv
module msync_fabric #(
   parameter int unsigned NUM_LINKS   = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RX_OUT_REG  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINKS-1:0] link_off_mask,
   input  logic [NUM_LINKS-1:0] tx_sync_in_n,
   output logic                 tx_sync_merged_n,
   input  logic                 rx_sync_req_n,
   output logic [NUM_LINKS-1:0] rx_sync_out_n
);
   import msync_pkg::*;

   // R9: configuration limits
   if (NUM_LINKS < 1 || NUM_LINKS > MSYNC_MAX_LINKS) begin : g_bad_links
      $error("msync_fabric: NUM_LINKS out of range");
   end
   if (SYNC_STAGES < MSYNC_MIN_STAGES) begin : g_bad_stages
      $error("msync_fabric: SYNC_STAGES too small");
   end

   logic [NUM_LINKS-1:0] tx_sync_s_n;

   msync_sync #(.WIDTH(NUM_LINKS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (tx_sync_in_n),
      .sync_out (tx_sync_s_n)
   );

   msync_merge #(.LINKS(NUM_LINKS)) u_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .off_mask (link_off_mask),
      .sync_n   (tx_sync_s_n),
      .merged_n (tx_sync_merged_n)
   );

   msync_fanout #(.LINKS(NUM_LINKS), .OUT_REG(RX_OUT_REG)) u_fanout (
      .clk      (clk),
      .rst_n    (rst_n),
      .off_mask (link_off_mask),
      .req_n    (rx_sync_req_n),
      .out_n    (rx_sync_out_n)
   );
endmodule

// File: rtl/msync_fabric_chk.sv
module msync_fabric_chk #(
   parameter int unsigned NUM_LINKS   = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RX_OUT_REG  = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINKS-1:0] link_off_mask,
   input logic [NUM_LINKS-1:0] tx_sync_in_n,
   input logic                 tx_sync_merged_n,
   input logic                 rx_sync_req_n,
   input logic [NUM_LINKS-1:0] rx_sync_out_n
);
   logic [1:0] live;   // edges since reset release, saturating at 3

   always_ff @(posedge clk) begin
      if (!rst_n)          live <= 2'd0;
      else if (live != 2'd3) live <= live + 2'd1;
   end

   assert_reset_idle_R1: assert property (@(posedge clk)
      $past(!rst_n) |-> (tx_sync_merged_n && (&rx_sync_out_n)));

   assert_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (live != 2'd0 && $past(&link_off_mask)) |-> tx_sync_merged_n);

   if (SYNC_STAGES == 2) begin : g_tx_lat
      // R2 R3 R5: merged level from inputs three edges back, mask one edge back
      assert_merge_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (live == 2'd3) |->
         (tx_sync_merged_n == ((($past(tx_sync_in_n, 3) | $past(link_off_mask)) == {NUM_LINKS{1'b1}}))));
   end

   if (RX_OUT_REG) begin : g_rx
      assert_rx_off_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (live != 2'd0) |-> ((rx_sync_out_n & $past(link_off_mask)) == $past(link_off_mask)));
      assert_rx_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (live != 2'd0) |->
         ((rx_sync_out_n & ~$past(link_off_mask)) == ({NUM_LINKS{$past(rx_sync_req_n)}} & ~$past(link_off_mask))));
   end
endmodule

bind msync_fabric msync_fabric_chk #(
   .NUM_LINKS(NUM_LINKS), .SYNC_STAGES(SYNC_STAGES), .RX_OUT_REG(RX_OUT_REG)
) u_chk (.*);

// File: tb/msync_fabric_test.sv
`timescale 1ns/1ps
module msync_fabric_test;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] link_off_mask = '0;
   logic [N-1:0] tx_sync_in_n = '1;
   logic         tx_sync_merged_n;
   logic         rx_sync_req_n = 1'b1;
   logic [N-1:0] rx_sync_out_n;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   msync_fabric #(.NUM_LINKS(N), .SYNC_STAGES(2), .RX_OUT_REG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .link_off_mask(link_off_mask),
      .tx_sync_in_n(tx_sync_in_n), .tx_sync_merged_n(tx_sync_merged_n),
      .rx_sync_req_n(rx_sync_req_n), .rx_sync_out_n(rx_sync_out_n)
   );

   function automatic logic exp_merged(input logic [N-1:0] m, input logic [N-1:0] s);
      logic any_low = 1'b0;
      for (int i = 0; i < N; i++)
         if (!m[i] && !s[i]) any_low = 1'b1;
      return !any_low;
   endfunction

   function automatic logic [N-1:0] exp_rx(input logic [N-1:0] m, input logic r);
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) v[i] = m[i] ? 1'b1 : r;
      return v;
   endfunction

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", req, act, expv);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: idle during reset
      chk("R1", {{(N-1){1'b0}}, tx_sync_merged_n}, {{(N-1){1'b0}}, 1'b1});
      chk("R1", rx_sync_out_n, '1);
      tx_sync_in_n  = '0;
      rx_sync_req_n = 1'b0;
      @(negedge clk);
      chk("R1", rx_sync_out_n, '1);
      rst_n = 1'b1;
      tx_sync_in_n  = '1;
      rx_sync_req_n = 1'b1;
      @(negedge clk);
      chk("R1", {{(N-1){1'b0}}, tx_sync_merged_n}, {{(N-1){1'b0}}, 1'b1});

      // R5: exact latency of three edges
      link_off_mask = '0;
      tx_sync_in_n  = '1;
      repeat (4) @(negedge clk);
      tx_sync_in_n = 4'b1011;
      repeat (2) @(negedge clk);
      chk("R5 after 2 edges", {3'b0, tx_sync_merged_n}, 4'b0001);
      @(negedge clk);
      chk("R5 after 3 edges", {3'b0, tx_sync_merged_n}, 4'b0000);

      // R2 R3 R4 R6 R7 R8: full sweep of masks, input patterns, request level
      for (int m = 0; m < 16; m++) begin
         for (int p = 0; p < 16; p++) begin
            link_off_mask = m[N-1:0];
            tx_sync_in_n  = p[N-1:0];
            rx_sync_req_n = p[0] ^ m[0];
            @(negedge clk);
            if (m[N-1:0] == '1) chk("R7 all off", rx_sync_out_n, exp_rx(m[N-1:0], p[0] ^ m[0]));
            else                chk("R6 R8 rx", rx_sync_out_n, exp_rx(m[N-1:0], p[0] ^ m[0]));
            repeat (2) @(negedge clk);
            if (m[N-1:0] == '1)
               chk("R4", {3'b0, tx_sync_merged_n}, 4'b0001);
            else
               chk("R2 R3 R8 tx", {3'b0, tx_sync_merged_n},
                   {3'b0, exp_merged(m[N-1:0], p[N-1:0])});
         end
      end

      // R3: a disabled link held low does not assert the merged line
      link_off_mask = 4'b0100;
      tx_sync_in_n  = 4'b1011;
      repeat (3) @(negedge clk);
      chk("R3 ignored link", {3'b0, tx_sync_merged_n}, 4'b0001);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule